// File: doc/BRIEF.md
# H-Bridge Control Input Mode Decoder

This block turns two logic-level control inputs into gate commands for the two half-bridges of a full H-bridge. Each half-bridge gets a high-side enable and a low-side enable. Both low means the half-bridge is in Hi-Z. Two control schemes are supported. In phase/enable operation, one input carries the PWM and the other sets the direction of current. In independent-PWM operation, each input drives PWM on its own side.

The scheme is chosen by a 2-bit mode value held in the block. A build parameter sets where that value comes from. In strapped builds, the strap pins are captured once, in the first cycle after sleep is released, and are ignored after that. In register builds, a write strobe loads the mode directly and the new decoding applies from the next cycle. Reserved codes, sleep and driver-off all give a safe Hi-Z response.

Half-bridge A is output index 0 and half-bridge B is index 1. All outputs are registered. A change on an input appears at the outputs after one clock edge. A mode write or a strap capture appears after two clock edges.

Top module: `hb_mode_decoder`

## Requirements
- R1: Mode code 2'b00 selects phase/enable decoding. With ctl_a=0, both low-sides are on and both high-sides are off (brake). With ctl_a=1 and ctl_b=1, hs_on=2'b01 and ls_on=2'b10. With ctl_a=1 and ctl_b=0, hs_on=2'b10 and ls_on=2'b01.
- R2: Mode code 2'b11 selects independent PWM decoding, using {ctl_a,ctl_b}. 00 gives Hi-Z on both sides (all outputs 0). 10 gives hs_on=2'b01 and ls_on=2'b10. 01 gives hs_on=2'b10 and ls_on=2'b01. 11 gives ls_on=2'b11 and hs_on=2'b00.
- R3: Reserved mode codes 2'b01 and 2'b10 drive all four outputs to 0, whatever the control inputs are.
- R4: When sleep_n is 0 or drv_off is 1, all outputs are 0 one edge later. This holds in every mode.
- R5: At the default input levels (sleep_n=0, drv_off=1, ctl_a=0, ctl_b=0), and during reset, all outputs are 0.
- R6: In a strapped build, strap_mode is captured in the first cycle with sleep_n=1 after reset or after a sleep. Later changes on strap_mode, and any write strobes, leave the decoding unchanged.
- R7: In a register build, a cycle with wr_en=1 loads wr_mode, and the decoding follows it from the next cycle. The strap pins have no effect.
- R8: hs_on[i] and ls_on[i] are never both 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_n | input | 1 | Low puts the bridge to sleep (Hi-Z) and re-arms strap capture |
| drv_off | input | 1 | High forces all outputs off |
| ctl_a | input | 1 | First control input (enable or side-A PWM) |
| ctl_b | input | 1 | Second control input (phase or side-B PWM) |
| strap_mode | input | 2 | Strapped mode code, used by strapped builds |
| wr_en | input | 1 | Mode write strobe, used by register builds |
| wr_mode | input | 2 | Mode code to write |
| hs_on | output | 2 | High-side enable per half-bridge (bit 0 = A) |
| ls_on | output | 2 | Low-side enable per half-bridge (bit 0 = A) |

## Verification
The bench builds the block twice, side by side on shared control inputs. One copy uses the strapped source and the other uses the register source. With both builds present, the mode latch and the write path are covered in the same run. For the register build, the bench sweeps every mode code against every combination of the two control inputs, sleep and driver-off. For the strapped build, it changes the strap pins during operation and across a sleep cycle, to show that they are ignored while running and re-sampled on wake.

// File: rtl/hb_mode_pkg.sv
package hb_mode_pkg;
    localparam int MODE_W = 2;
    localparam int NUM_HB = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_PHEN  = 2'b00,
        MODE_RSV1  = 2'b01,
        MODE_RSV2  = 2'b10,
        MODE_INDEP = 2'b11
    } hb_mode_e;

    typedef struct packed {
        hb_mode_e          mode;
        logic              arm;
        logic              past_vld;
        logic [NUM_HB-1:0] hs;
        logic [NUM_HB-1:0] ls;
    } hb_state_t;
endpackage

// File: rtl/hb_mode_store.sv
module hb_mode_store
    import hb_mode_pkg::*;
#(
    parameter bit STRAP_SRC = 1'b1
) (
    input  hb_mode_e          mode_q,
    input  logic              arm_q,
    input  logic              sleep_n,
    input  logic [MODE_W-1:0] strap_mode,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] wr_mode,
    output hb_mode_e          mode_d,
    output logic              arm_d,
    output logic              mode_ok
);
    logic [MODE_W-1:0] src_mode;
    logic              load;

    always_comb begin
        src_mode = STRAP_SRC ? strap_mode : wr_mode;
        load     = STRAP_SRC ? (arm_q & sleep_n) : wr_en;
        mode_d   = load ? hb_mode_e'(src_mode) : mode_q;
        // strapped builds re-arm while asleep; register builds never arm
        arm_d    = STRAP_SRC ? ~sleep_n : 1'b0;
        mode_ok  = ~arm_q;
    end
endmodule

// File: rtl/hb_bridge_decode.sv
module hb_bridge_decode
    import hb_mode_pkg::*;
(
    input  hb_mode_e          mode,
    input  logic              active,
    input  logic              ctl_a,
    input  logic              ctl_b,
    output logic [NUM_HB-1:0] hs_d,
    output logic [NUM_HB-1:0] ls_d
);
    always_comb begin
        hs_d = '0;
        ls_d = '0;
        if (active) begin
            unique case (mode)
                MODE_PHEN: begin
                    if (!ctl_a) begin
                        ls_d = 2'b11;
                    end else if (ctl_b) begin
                        hs_d = 2'b01;
                        ls_d = 2'b10;
                    end else begin
                        hs_d = 2'b10;
                        ls_d = 2'b01;
                    end
                end
                MODE_INDEP: begin
                    unique case ({ctl_a, ctl_b})
                        2'b10: begin hs_d = 2'b01; ls_d = 2'b10; end
                        2'b01: begin hs_d = 2'b10; ls_d = 2'b01; end
                        2'b11: ls_d = 2'b11;
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/hb_mode_decoder.sv
module hb_mode_decoder
    import hb_mode_pkg::*;
#(
    parameter bit STRAP_SRC = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_n,
    input  logic              drv_off,
    input  logic              ctl_a,
    input  logic              ctl_b,
    input  logic [MODE_W-1:0] strap_mode,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] wr_mode,
    output logic [NUM_HB-1:0] hs_on,
    output logic [NUM_HB-1:0] ls_on
);
    hb_state_t st_d, st_q;
    hb_mode_e  mode_nx;
    logic      arm_nx, mode_ok;
    logic [NUM_HB-1:0] hs_nx, ls_nx;

    hb_mode_store #(.STRAP_SRC(STRAP_SRC)) store_i (
        .mode_q     (st_q.mode),
        .arm_q      (st_q.arm),
        .sleep_n    (sleep_n),
        .strap_mode (strap_mode),
        .wr_en      (wr_en),
        .wr_mode    (wr_mode),
        .mode_d     (mode_nx),
        .arm_d      (arm_nx),
        .mode_ok    (mode_ok)
    );

    hb_bridge_decode dec_i (
        .mode   (st_q.mode),
        .active (mode_ok & sleep_n & ~drv_off),
        .ctl_a  (ctl_a),
        .ctl_b  (ctl_b),
        .hs_d   (hs_nx),
        .ls_d   (ls_nx)
    );

    always_comb begin
        st_d          = st_q;
        st_d.mode     = mode_nx;
        st_d.arm      = arm_nx;
        st_d.past_vld = 1'b1;
        st_d.hs       = hs_nx;
        st_d.ls       = ls_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_PHEN, arm: 1'b1, past_vld: 1'b0,
                      hs: '0, ls: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign hs_on = st_q.hs;
    assign ls_on = st_q.ls;

    assert_no_shoot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_on & ls_on) == '0);

    assert_off_hiz_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.past_vld && (!sleep_n || drv_off)) |=> (hs_on == '0 && ls_on == '0));

    assert_rsv_hiz_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_RSV1 || st_q.mode == MODE_RSV2) |=>
            (hs_on == '0 && ls_on == '0));

    generate
        if (STRAP_SRC) begin : g_strap_chk
            assert_strap_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.past_vld && !st_q.arm) |=> $stable(st_q.mode));
        end else begin : g_reg_chk
            assert_wr_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en |=> (st_q.mode == $past(wr_mode)));
        end
    endgenerate
endmodule

// File: tb/hb_mode_decoder_tb.sv
module hb_mode_decoder_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_n = 1'b0, drv_off = 1'b1, ctl_a = 1'b0, ctl_b = 1'b0;
    logic [1:0] strap = 2'b00, wmode = 2'b00;
    logic wr_en = 1'b0;
    logic [1:0] hs_s, ls_s, hs_r, ls_r;
    int n_chk = 0, n_err = 0;

    always #4 clk = ~clk;

    hb_mode_decoder #(.STRAP_SRC(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .drv_off(drv_off),
        .ctl_a(ctl_a), .ctl_b(ctl_b), .strap_mode(strap), .wr_en(wr_en),
        .wr_mode(wmode), .hs_on(hs_s), .ls_on(ls_s));

    hb_mode_decoder #(.STRAP_SRC(1'b0)) dut_reg_i (
        .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .drv_off(drv_off),
        .ctl_a(ctl_a), .ctl_b(ctl_b), .strap_mode(~strap), .wr_en(wr_en),
        .wr_mode(wmode), .hs_on(hs_r), .ls_on(ls_r));

    function automatic logic [3:0] expect_out(input logic [1:0] m, input logic on,
                                              input logic a, input logic b);
        if (!on) return 4'b0000;
        if (m == 2'b00) begin
            if (!a) return 4'b0011;        // {hs,ls}
            return b ? 4'b0110 : 4'b1001;
        end
        if (m == 2'b11) begin
            case ({a, b})
                2'b10: return 4'b0110;
                2'b01: return 4'b1001;
                2'b11: return 4'b0011;
                default: return 4'b0000;
            endcase
        end
        return 4'b0000;
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got hs/ls=%b expected %b", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic write_mode(input logic [1:0] m);
        @(negedge clk);
        wmode = m; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        check("R5 reset strap", {hs_s, ls_s}, 4'b0000);
        check("R5 reset reg", {hs_r, ls_r}, 4'b0000);
        rst_n = 1'b1;
        settle();
        check("R5 default levels strap", {hs_s, ls_s}, 4'b0000);
        check("R5 default levels reg", {hs_r, ls_r}, 4'b0000);

        // strap capture of 11 on wake
        strap = 2'b11;
        sleep_n = 1'b1; drv_off = 1'b0;
        settle();
        strap = 2'b00;                       // change while running: ignored (R6)
        write_mode(2'b00);                   // write ignored by strapped build (R6)
        for (int ab = 0; ab < 4; ab++) begin
            ctl_a = ab[1]; ctl_b = ab[0];
            settle();
            check("R6 R2 strap held indep", {hs_s, ls_s}, expect_out(2'b11, 1'b1, ctl_a, ctl_b));
        end

        // sleep then wake re-captures 00
        sleep_n = 1'b0;
        settle();
        check("R4 sleep strap", {hs_s, ls_s}, 4'b0000);
        sleep_n = 1'b1;
        settle();
        strap = 2'b11;
        for (int ab = 0; ab < 4; ab++) begin
            ctl_a = ab[1]; ctl_b = ab[0];
            settle();
            check("R6 R1 strap recapture phen", {hs_s, ls_s}, expect_out(2'b00, 1'b1, ctl_a, ctl_b));
        end

        // strap reserved code gives Hi-Z
        sleep_n = 1'b0; strap = 2'b10;
        settle();
        sleep_n = 1'b1;
        settle();
        ctl_a = 1'b1; ctl_b = 1'b0;
        settle();
        check("R3 strap reserved", {hs_s, ls_s}, 4'b0000);

        // register build: exhaustive sweep
        for (int m = 0; m < 4; m++) begin
            write_mode(m[1:0]);
            for (int v = 0; v < 16; v++) begin
                sleep_n = v[3]; drv_off = v[2]; ctl_a = v[1]; ctl_b = v[0];
                settle();
                check("R1 R2 R3 R4 R7 reg sweep", {hs_r, ls_r},
                      expect_out(m[1:0], sleep_n & ~drv_off, ctl_a, ctl_b));
                check("R8 exclusive", {2'b00, hs_r & ls_r}, 4'b0000);
            end
        end

        // R7: decoding follows the write from the next cycle
        sleep_n = 1'b1; drv_off = 1'b0; ctl_a = 1'b0; ctl_b = 1'b0;
        write_mode(2'b11);
        settle();
        check("R7 indep coast", {hs_r, ls_r}, 4'b0000);
        @(negedge clk);
        wmode = 2'b00; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        check("R7 next-cycle brake", {hs_r, ls_r}, 4'b0011);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule